// File: doc/BRIEF.md
# Channel Request Qualifier and Priority Arbiter

This block sits in front of a multi-channel DMA engine. Every channel has a peripheral single-request line, a peripheral burst-request line and a software request bit. The block combines these with the controller enable, the per-channel enable, the request mask, the burst-only mode and the priority level. The result is a qualified request vector. From that vector the block picks one channel for the engine to service. It reports the winner's index, a valid flag and whether the unit is to be moved as a burst or as a single transfer. The grant stays fixed until the engine signals the end of the current arbitration unit.

Burst-only mode is held inside the block as one bit per channel. Software sets and clears these bits with one-cycle pulses. At the end of each unit the engine reports two values for the granted channel: how many items are still left, and that channel's arbitration size. When fewer items are left than one arbitration unit, the block clears the channel's burst-only bit so the tail can finish on single requests. A per-channel wait status shows every enabled channel that is neither requesting nor being serviced.

Top module: `dma_req_arbiter`

## Requirements
- R1: A channel's request qualifies only while both `master_en` and its `ch_en` bit are 1.
- R2: While a channel's `req_mask` bit is 1, its `single_req` and `burst_req` lines are ignored. A `sw_req` on that channel still qualifies it.
- R3: While a channel's `burst_only` bit is 1, its `single_req` cannot qualify it. An unmasked `burst_req` still can.
- R4: `burst_only[n]` is set by a one-cycle pulse on `burst_set[n]` and cleared by a pulse on `burst_clr[n]`. A clear wins over a set in the same cycle. The change is visible one cycle after the pulse.
- R5: At a clock edge where `grant_valid` and `unit_done` are both 1, the granted channel's `burst_only` bit is cleared if `done_left < done_unit_sz`. This includes `done_left == 0`, which is the end of a transfer that was an exact multiple of the unit.
- R6: If any qualified channel has its `prio_hi` bit set, the grant goes to one of those channels, never to a default-priority channel.
- R7: Within the winning priority level, the lowest-numbered qualified channel wins.
- R8: The grant is loaded at a clock edge where `grant_valid` is 0 or `unit_done` is 1. At every other edge, `grant_valid`, `grant_ch` and `grant_burst` keep their values. When nothing qualifies at a load edge, `grant_valid` becomes 0.
- R9: `grant_burst` is 1 when the winning channel has a software request or a qualified peripheral burst request. It is 0 when only its single request qualifies, and 0 while `grant_valid` is 0.
- R10: `wait_stat[n]` is 1 exactly when channel n is eligible under R1, does not qualify, and is not the channel currently granted.
- R11: After a synchronous active-low reset, `grant_valid`, `grant_ch`, `grant_burst` and every `burst_only` bit are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| master_en | input | 1 | Controller-wide enable |
| ch_en | input | NUM_CH | Per-channel enable |
| req_mask | input | NUM_CH | Blocks peripheral requests per channel |
| prio_hi | input | NUM_CH | Places the channel in the high priority level |
| sw_req | input | NUM_CH | Software request per channel |
| single_req | input | NUM_CH | Peripheral single-request lines |
| burst_req | input | NUM_CH | Peripheral burst-request lines |
| burst_set | input | NUM_CH | Pulse: enter burst-only mode |
| burst_clr | input | NUM_CH | Pulse: leave burst-only mode |
| unit_done | input | 1 | Engine finished the current arbitration unit |
| done_left | input | CNT_W | Items still left on the granted channel at `unit_done` |
| done_unit_sz | input | CNT_W | Arbitration size of the granted channel |
| qual_req | output | NUM_CH | Qualified request vector |
| grant_valid | output | 1 | A channel is granted |
| grant_ch | output | IDX_W | Granted channel index |
| grant_burst | output | 1 | 1 = burst unit, 0 = single transfer |
| burst_only | output | NUM_CH | Current burst-only mode bits |
| wait_stat | output | NUM_CH | Channel enabled and waiting on a request |

## Verification
The assertions check several properties on every cycle. The grant holds between unit ends. Every newly loaded grant names a channel that was qualified on the cycle before. A newly loaded grant never names a masked channel that had no software request. A default-priority channel never wins while a high-priority channel is qualified. A burst-only bit never rises without a set pulse. Wait status and qualified requests never overlap. Other behaviour is shown only by the bench, which compares against its reference model: the lowest-index ordering, the burst or single kind of each grant, and the automatic clearing of burst-only mode for a short or zero remainder.

// File: rtl/dma_arb_pkg.sv
// Shared types for the DMA request arbiter.
package dma_arb_pkg;
    // Kind of transfer unit handed to the engine.
    typedef enum logic {
        XFER_SINGLE = 1'b0,
        XFER_BURST  = 1'b1
    } xfer_kind_e;
endpackage

// File: rtl/rq_qualify.sv
// Per-channel request qualification.
// Combines controller and channel enables, the peripheral request mask,
// burst-only mode and the three request sources into a qualified request.
// It also reports whether a qualified request asks for a burst unit.
// Assumes all inputs are synchronous to the arbiter clock.
module rq_qualify #(
    parameter int NUM_CH = 32
) (
    input  logic              master_en,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] req_mask,
    input  logic [NUM_CH-1:0] burst_only,
    input  logic [NUM_CH-1:0] sw_req,
    input  logic [NUM_CH-1:0] single_req,
    input  logic [NUM_CH-1:0] burst_req,
    output logic [NUM_CH-1:0] eligible,
    output logic [NUM_CH-1:0] qual,
    output logic [NUM_CH-1:0] want_burst
);
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic per_burst;
        logic per_single;
        // Peripheral lines pass only when unmasked; single also needs burst-only off.
        always_comb begin
            per_burst     = burst_req[n] & ~req_mask[n];
            per_single    = single_req[n] & ~req_mask[n] & ~burst_only[n];
            eligible[n]   = master_en & ch_en[n];
            qual[n]       = eligible[n] & (sw_req[n] | per_burst | per_single);
            want_burst[n] = sw_req[n] | per_burst;
        end
    end
endmodule

// File: rtl/rq_pick.sv
// Two-level fixed-priority picker.
// The high level wins whenever it has a candidate. Within a level the
// lowest index wins. The index is 0 when nothing is requesting.
module rq_pick #(
    parameter int NUM_CH = 32,
    parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] qual,
    input  logic [NUM_CH-1:0] prio_hi,
    output logic              any,
    output logic [IDX_W-1:0]  win
);
    logic [NUM_CH-1:0] hi_cand;
    logic [NUM_CH-1:0] cand;

    // Narrow the candidate set to the high level when it is populated.
    always_comb begin
        hi_cand = qual & prio_hi;
        cand    = (|hi_cand) ? hi_cand : qual;
        any     = |qual;
    end

    // Lowest set index of the candidate set.
    always_comb begin
        win = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (cand[i]) win = IDX_W'(i);
        end
    end
endmodule

// File: rtl/burst_mode_reg.sv
// Burst-only mode bits, one per channel.
// Software sets and clears a bit with pulses; a clear wins over a set.
// At the end of a unit, the granted channel's bit drops when fewer items
// remain than one arbitration unit.
module burst_mode_reg #(
    parameter int NUM_CH = 32,
    parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_p,
    input  logic [NUM_CH-1:0] clr_p,
    input  logic              done_fire,
    input  logic [IDX_W-1:0]  done_ch,
    input  logic [CNT_W-1:0]  done_left,
    input  logic [CNT_W-1:0]  done_unit_sz,
    output logic [NUM_CH-1:0] mode_q
);
    logic tail_short;

    // A remainder shorter than one unit (zero included) ends burst-only mode.
    always_comb tail_short = done_left < done_unit_sz;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_bit
        logic auto_clr;
        // Automatic clear applies only to the channel that just finished a unit.
        always_comb auto_clr = done_fire & tail_short & (done_ch == IDX_W'(n));
        // Mode bit state update.
        always_ff @(posedge clk) begin
            if (!rst_n)                     mode_q[n] <= 1'b0;
            else if (clr_p[n] || auto_clr)  mode_q[n] <= 1'b0;
            else if (set_p[n])              mode_q[n] <= 1'b1;
        end
    end
endmodule

// File: rtl/dma_req_arbiter.sv
// DMA request qualifier and priority arbiter (top).
// Qualifies the per-channel requests and picks one channel with a two-level
// fixed priority. The grant is held until the engine pulses unit_done.
// Also keeps the burst-only mode bits and reports the per-channel wait status.
// Assumes unit_done is pulsed only while a grant is valid, and that
// done_left / done_unit_sz describe the granted channel in that cycle.
module dma_req_arbiter #(
    parameter int NUM_CH = 32,
    parameter int CNT_W  = 10,
    parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] req_mask,
    input  logic [NUM_CH-1:0] prio_hi,
    input  logic [NUM_CH-1:0] sw_req,
    input  logic [NUM_CH-1:0] single_req,
    input  logic [NUM_CH-1:0] burst_req,
    input  logic [NUM_CH-1:0] burst_set,
    input  logic [NUM_CH-1:0] burst_clr,
    input  logic              unit_done,
    input  logic [CNT_W-1:0]  done_left,
    input  logic [CNT_W-1:0]  done_unit_sz,
    output logic [NUM_CH-1:0] qual_req,
    output logic              grant_valid,
    output logic [IDX_W-1:0]  grant_ch,
    output logic              grant_burst,
    output logic [NUM_CH-1:0] burst_only,
    output logic [NUM_CH-1:0] wait_stat
);
    import dma_arb_pkg::*;

    logic [NUM_CH-1:0] eligible;
    logic [NUM_CH-1:0] want_burst;
    logic [NUM_CH-1:0] held_mask;
    logic              any_req;
    logic [IDX_W-1:0]  win_idx;
    logic              load_grant;
    xfer_kind_e        grant_kind;
    xfer_kind_e        win_kind;

    rq_qualify #(.NUM_CH(NUM_CH)) u_qual (
        .master_en  (master_en),
        .ch_en      (ch_en),
        .req_mask   (req_mask),
        .burst_only (burst_only),
        .sw_req     (sw_req),
        .single_req (single_req),
        .burst_req  (burst_req),
        .eligible   (eligible),
        .qual       (qual_req),
        .want_burst (want_burst)
    );

    rq_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
        .qual    (qual_req),
        .prio_hi (prio_hi),
        .any     (any_req),
        .win     (win_idx)
    );

    burst_mode_reg #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_p        (burst_set),
        .clr_p        (burst_clr),
        .done_fire    (grant_valid & unit_done),
        .done_ch      (grant_ch),
        .done_left    (done_left),
        .done_unit_sz (done_unit_sz),
        .mode_q       (burst_only)
    );

    // Arbitration point: when idle, or when the current unit is finishing.
    always_comb begin
        load_grant = !grant_valid || unit_done;
        win_kind   = (any_req && want_burst[win_idx]) ? XFER_BURST : XFER_SINGLE;
    end

    // Grant register: loaded at an arbitration point, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_ch    <= '0;
            grant_kind  <= XFER_SINGLE;
        end else if (load_grant) begin
            grant_valid <= any_req;
            grant_ch    <= win_idx;
            grant_kind  <= win_kind;
        end
    end

    // Wait status: eligible, not requesting, not being serviced.
    always_comb begin
        held_mask   = grant_valid ? (NUM_CH'(1) << grant_ch) : '0;
        wait_stat   = eligible & ~qual_req & ~held_mask;
        grant_burst = (grant_kind == XFER_BURST);
    end
endmodule

// File: rtl/dma_arb_chk.sv
// Assertion checker for dma_req_arbiter, attached by bind below.
// Keeps one-cycle copies of the inputs it needs, so that each newly loaded
// grant can be related to the request state it was chosen from.
module dma_arb_chk #(
    parameter int NUM_CH = 32,
    parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] prio_hi,
    input logic [NUM_CH-1:0] req_mask,
    input logic [NUM_CH-1:0] sw_req,
    input logic [NUM_CH-1:0] burst_set,
    input logic              unit_done,
    input logic [NUM_CH-1:0] qual_req,
    input logic              grant_valid,
    input logic [IDX_W-1:0]  grant_ch,
    input logic              grant_burst,
    input logic [NUM_CH-1:0] burst_only,
    input logic [NUM_CH-1:0] wait_stat
);
    logic [NUM_CH-1:0] qual_d, hi_d, mask_d, sw_d, bo_d, set_d;
    logic              gv_d, done_d;
    logic              new_grant;

    // One-cycle history of the observed signals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual_d <= '0; hi_d <= '0; mask_d <= '0; sw_d <= '0;
            bo_d   <= '0; set_d <= '0; gv_d <= 1'b0; done_d <= 1'b0;
        end else begin
            qual_d <= qual_req; hi_d <= prio_hi; mask_d <= req_mask;
            sw_d   <= sw_req;   bo_d <= burst_only; set_d <= burst_set;
            gv_d   <= grant_valid; done_d <= unit_done;
        end
    end

    // A grant loaded at the previous edge.
    always_comb new_grant = grant_valid && (!gv_d || done_d);

    assert_grant_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !unit_done) |=>
            (grant_valid && $stable(grant_ch) && $stable(grant_burst)));

    assert_grant_from_qual_R1: assert property (@(posedge clk) disable iff (!rst_n)
        new_grant |-> qual_d[grant_ch]);

    assert_high_level_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (new_grant && !hi_d[grant_ch]) |-> ((qual_d & hi_d) == '0));

    assert_masked_needs_sw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        new_grant |-> !(mask_d[grant_ch] && !sw_d[grant_ch]));

    assert_mode_rise_needs_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_only & ~bo_d & ~set_d) == '0);

    assert_wait_excludes_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_stat & qual_req) == '0);

    assert_idle_not_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> !grant_burst);
endmodule

bind dma_req_arbiter dma_arb_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prio_hi     (prio_hi),
    .req_mask    (req_mask),
    .sw_req      (sw_req),
    .burst_set   (burst_set),
    .unit_done   (unit_done),
    .qual_req    (qual_req),
    .grant_valid (grant_valid),
    .grant_ch    (grant_ch),
    .grant_burst (grant_burst),
    .burst_only  (burst_only),
    .wait_stat   (wait_stat)
);

// File: tb/tb_dma_req_arbiter.sv
// Bench: behavioural reference model compared on every clock, with directed
// scenarios followed by random traffic.
module tb_dma_req_arbiter;
    localparam int N  = 32;
    localparam int CW = 10;
    localparam int IW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_en = 1'b0;
    logic [N-1:0] ch_en = '0, req_mask = '0, prio_hi = '0, sw_req = '0;
    logic [N-1:0] single_req = '0, burst_req = '0, burst_set = '0, burst_clr = '0;
    logic unit_done = 1'b0;
    logic [CW-1:0] done_left = '0, done_unit_sz = '0;
    logic [N-1:0] qual_req, burst_only, wait_stat;
    logic grant_valid, grant_burst;
    logic [IW-1:0] grant_ch;

    int vectors = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference model state.
    bit m_gv, m_gb;
    int m_ch;
    bit [N-1:0] m_bo;

    always #5 clk = ~clk;

    dma_req_arbiter #(.NUM_CH(N), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .ch_en(ch_en),
        .req_mask(req_mask), .prio_hi(prio_hi), .sw_req(sw_req),
        .single_req(single_req), .burst_req(burst_req), .burst_set(burst_set),
        .burst_clr(burst_clr), .unit_done(unit_done), .done_left(done_left),
        .done_unit_sz(done_unit_sz), .qual_req(qual_req), .grant_valid(grant_valid),
        .grant_ch(grant_ch), .grant_burst(grant_burst), .burst_only(burst_only),
        .wait_stat(wait_stat)
    );

    task automatic cmp(input logic [63:0] act, input logic [63:0] exp, input string what);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", what, act, exp, $time);
        end
    endtask

    // One cycle: compare all outputs against the model, then advance both.
    task automatic step();
        bit [N-1:0] q, wb, wt, bo_n;
        int w;
        bit found;
        #1;
        for (int n = 0; n < N; n++) begin
            bit el, pb, ps;
            el = master_en && ch_en[n];
            pb = burst_req[n] && !req_mask[n];
            ps = single_req[n] && !req_mask[n] && !m_bo[n];
            q[n]  = el && (sw_req[n] || pb || ps);
            wb[n] = sw_req[n] || pb;
            wt[n] = el && !q[n] && !(m_gv && m_ch == n);
        end
        vectors++;
        cmp(64'(qual_req), 64'(q), "R1 R2 R3 qual_req");
        cmp(64'(wait_stat), 64'(wt), "R10 wait_stat");
        cmp(64'(grant_valid), 64'(m_gv), "R8 grant_valid");
        cmp(64'(grant_ch), 64'(m_ch), "R6 R7 grant_ch");
        cmp(64'(grant_burst), 64'(m_gb), "R9 grant_burst");
        cmp(64'(burst_only), 64'(m_bo), "R4 R5 burst_only");
        // Pick: high level first, then lowest index.
        found = 0; w = 0;
        for (int n = 0; n < N; n++) if (!found && q[n] && prio_hi[n]) begin found = 1; w = n; end
        for (int n = 0; n < N; n++) if (!found && q[n]) begin found = 1; w = n; end
        for (int n = 0; n < N; n++) begin
            bo_n[n] = m_bo[n] || burst_set[n];
            if (burst_clr[n]) bo_n[n] = 0;
            if (m_gv && unit_done && m_ch == n && done_left < done_unit_sz) bo_n[n] = 0;
        end
        @(posedge clk);
        if (!rst_n) begin
            m_gv = 0; m_ch = 0; m_gb = 0; m_bo = '0;
        end else begin
            if (!m_gv || unit_done) begin
                m_gv = found; m_ch = w; m_gb = found && wb[w];
            end
            m_bo = bo_n;
        end
        @(negedge clk);
    endtask

    task automatic pulses_off();
        burst_set = '0; burst_clr = '0; unit_done = 1'b0;
    endtask

    initial begin
        // Watchdog: a hung run is counted as a failure.
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        m_gv = 0; m_gb = 0; m_ch = 0; m_bo = '0;
        @(negedge clk);
        burst_set = '1; ch_en = '1; single_req = '1;
        repeat (3) step();
        burst_set = '0;
        rst_n = 1'b1;
        // R11: reset state.
        cmp(64'({grant_valid, grant_burst}), 64'(0), "R11 grant after reset");
        cmp(64'(grant_ch), 64'(0), "R11 grant_ch after reset");
        cmp(64'(burst_only), 64'(0), "R11 burst_only after reset");
        // R1: no qualification without master enable.
        single_req = '0; single_req[3] = 1;
        step();
        cmp(64'(qual_req), 64'(0), "R1 master_en low");
        master_en = 1;
        // R7: lowest index wins within a level.
        single_req[3] = 0; single_req[5] = 1; burst_req[9] = 1;
        step();
        cmp(64'(grant_ch), 64'(5), "R7 lowest index");
        cmp(64'(grant_burst), 64'(0), "R9 single grant");
        // R8: hold while a lower channel appears.
        single_req[1] = 1;
        step(); step();
        cmp(64'(grant_ch), 64'(5), "R8 grant held");
        unit_done = 1; step(); unit_done = 0;
        cmp(64'(grant_ch), 64'(1), "R8 re-arbitrated");
        // R6: high level beats a lower index.
        prio_hi[20] = 1; single_req[20] = 1;
        unit_done = 1; step(); unit_done = 0;
        cmp(64'(grant_ch), 64'(20), "R6 high priority wins");
        single_req = '0; burst_req = '0; prio_hi = '0;
        unit_done = 1; step(); unit_done = 0;
        // R2: mask blocks peripheral lines, software still qualifies.
        req_mask[7] = 1; single_req[7] = 1; burst_req[7] = 1;
        step();
        cmp(64'(qual_req[7]), 64'(0), "R2 masked peripheral");
        cmp(64'(wait_stat[7]), 64'(1), "R10 masked channel waits");
        sw_req[7] = 1; step();
        cmp(64'(qual_req[7]), 64'(1), "R2 software on masked channel");
        step();
        cmp(64'({grant_valid, grant_burst}), 64'(3), "R9 software grant is burst");
        sw_req = '0; single_req = '0; burst_req = '0; req_mask = '0;
        unit_done = 1; step(); unit_done = 0;
        // R3/R4: burst-only blocks single requests.
        burst_set[4] = 1; step(); burst_set = '0;
        cmp(64'(burst_only[4]), 64'(1), "R4 set pulse");
        single_req[4] = 1; step();
        cmp(64'(qual_req[4]), 64'(0), "R3 single blocked");
        burst_req[4] = 1; step(); step();
        cmp(64'({grant_valid, grant_burst, grant_ch}), 64'({2'b11, 5'd4}), "R3 burst grant");
        // R5: remainder equal to unit keeps mode, shorter clears it.
        done_left = 10'd4; done_unit_sz = 10'd4; unit_done = 1; step(); unit_done = 0;
        cmp(64'(burst_only[4]), 64'(1), "R5 kept when left == size");
        done_left = 10'd3; unit_done = 1; step(); unit_done = 0;
        cmp(64'(burst_only[4]), 64'(0), "R5 cleared when left < size");
        // R5: exact multiple, zero left.
        burst_set[4] = 1; unit_done = 1; done_left = 10'd4; step(); pulses_off();
        done_left = 10'd0; unit_done = 1; step(); unit_done = 0;
        cmp(64'(burst_only[4]), 64'(0), "R5 cleared at zero left");
        // R4: clear wins over set.
        burst_set[6] = 1; burst_clr[6] = 1; step(); pulses_off();
        cmp(64'(burst_only[6]), 64'(0), "R4 clear wins");
        single_req = '0; burst_req = '0;
        // Random traffic.
        for (int c = 0; c < 4000; c++) begin
            master_en  = ($urandom % 16) != 0;
            ch_en      = $urandom | $urandom;
            req_mask   = $urandom & $urandom;
            prio_hi    = $urandom & $urandom & $urandom;
            sw_req     = $urandom & $urandom & $urandom & $urandom;
            single_req = $urandom & $urandom & $urandom;
            burst_req  = $urandom & $urandom & $urandom;
            burst_set  = $urandom & $urandom & $urandom;
            burst_clr  = $urandom & $urandom & $urandom & $urandom;
            unit_done  = ($urandom % 3) == 0;
            done_left  = CW'($urandom % 12);
            done_unit_sz = CW'(1 << ($urandom % 4));
            if (c % 500 == 499) rst_n = 1'b0; else rst_n = 1'b1;
            step();
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule